// File: doc/BRIEF.md
# Four-Channel Descriptor DMA Engine

This block moves 32-bit words between locations on a single memory port under the control of per-channel descriptors. Each channel owns eight 32-bit descriptor words in a local store. Software fills in source and destination addresses, a byte count for one burst (the minor loop), signed address steps, and an iteration count for the whole job (the major loop). Software then starts the channel with a control bit. A peripheral can also start it through a request line once hardware requests are enabled for that channel.

The engine serves one channel per pass. It picks the pending channel with the highest programmed level, copies that channel's whole descriptor into working registers, and checks it. It then copies one burst as alternating read and write beats. After the burst it stores the advanced addresses and the decremented iteration count back into the descriptor. A long job therefore takes many passes, and the channel is arbitrated again before each one. When the last iteration finishes, the channel rearms itself from its starting count and stops, and a per-channel completion flag can be raised.

Top module: `dma_desc_engine`

## Requirements
- R1: A channel is pending when bit 0 (start) of its control word (descriptor word 6) is 1, or when its request line is high and its bit in the hardware-enable register (address 36) is 1. A high request line with the enable bit at 0 causes no bus traffic.
- R2: Among pending channels, the one with the largest level in its priority register (addresses 32 to 35, one per channel) is served. Equal levels go to the lower channel index.
- R3: A descriptor is rejected in any of these cases: the byte count (word 2) is zero or not a multiple of 4, the source (word 0) or destination (word 1) address has either of its low two bits set, or the current count (word 4, bits 15:0) is zero. For a rejected descriptor there is no bus traffic, the channel's error flag is set and its start bit is cleared. The channel is never served while its error flag is set.
- R4: The error interrupt output is high exactly when some channel has its error flag set and its bit in the error-enable register (address 37) is 1.
- R5: A pass moves byte count / 4 words. Each word is read at the source address, and in the next cycle it is written to the destination address with the data returned.
- R6: After each word, the source address advances by the signed 16-bit step in word 3 bits 15:0, and the destination address advances by the signed 16-bit step in word 3 bits 31:16.
- R7: At the end of a pass, only words 0, 1 and 4 of the descriptor are updated (advanced addresses and count minus one). The other words keep their values.
- R8: When a pass ends with a current count of 1, the following happens: word 4 is reloaded from word 5 bits 15:0, the start bit and the channel's hardware-enable bit are cleared, and the channel's completion flag is set only if bit 1 of word 6 is 1.
- R9: Each pass moves exactly one burst. A higher-level channel that becomes pending during a pass is served before the next pass of the running channel.
- R10: After reset, all flags, enables, levels and descriptor words are zero, and the memory port is idle.
- R11: Writing 1s to address 38 clears the matching completion flags. Writing 1s to address 39 clears the matching error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register/descriptor write strobe |
| cfg_addr | input | RA (6) | Word address: 0-31 descriptors (channel*8+word), 32-39 control |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Combinational read data at cfg_addr |
| hw_req | input | NCH | Per-channel peripheral request lines |
| mem_en | output | 1 | Memory beat valid |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | 32 | Byte address of the beat |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read beat |
| irq_done | output | NCH | Per-channel completion flags |
| err_flag | output | NCH | Per-channel configuration error flags |
| irq_err | output | 1 | Enabled error interrupt |

## Verification
The bench builds the engine with its defaults: four channels, 2-bit levels and 16-bit counts. Four channels are enough to let two pairs compete in one run. One pair has equal levels and shows the index tie-break. The other pair has inverted levels and shows a higher index winning. A third pair shows a high-level start landing between two passes of a running job. The 2-bit level covers both the equal-level and the strictly-greater comparison, and 16-bit steps reach a negative source stride.

// File: rtl/dma_desc_engine.sv
module dma_desc_engine #(
  parameter int NCH = 4,
  parameter int PW  = 2,
  parameter int CW  = 16,
  parameter int RA  = $clog2(NCH*8 + NCH + 4)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [RA-1:0]  cfg_addr,
  input  logic [31:0]    cfg_wdata,
  output logic [31:0]    cfg_rdata,
  input  logic [NCH-1:0] hw_req,
  output logic           mem_en,
  output logic           mem_we,
  output logic [31:0]    mem_addr,
  output logic [31:0]    mem_wdata,
  input  logic [31:0]    mem_rdata,
  output logic [NCH-1:0] irq_done,
  output logic [NCH-1:0] err_flag,
  output logic           irq_err
);
  localparam int CH_W = $clog2(NCH);
  localparam logic [RA-1:0] A_PRIO = RA'(NCH*8);
  localparam logic [RA-1:0] A_HWEN = RA'(NCH*8 + NCH);
  localparam logic [RA-1:0] A_EEI  = RA'(NCH*8 + NCH + 1);
  localparam logic [RA-1:0] A_DONE = RA'(NCH*8 + NCH + 2);
  localparam logic [RA-1:0] A_ERR  = RA'(NCH*8 + NCH + 3);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_RD, S_WR, S_WB} st_t;

  logic [31:0]     desc [NCH*8];
  logic [PW-1:0]   prio [NCH];
  logic [NCH-1:0]  hw_en, eei, done_q, err_q, start_v, pend;
  st_t             st;
  logic [CH_W-1:0] ch, win;
  logic [31:0]     sa, da, nb_left;
  logic [15:0]     soff, doff;
  logic [CW-1:0]   citer, biter;
  logic [31:0]     d_sa, d_da, d_nb, d_off;
  logic [CW-1:0]   d_ci, d_bi;
  logic            cfg_bad;

  always_comb
    for (int c = 0; c < NCH; c++) start_v[c] = desc[c*8 + 6][0];

  assign pend = ~err_q & (start_v | (hw_en & hw_req));

  always_comb begin
    logic          found;
    logic [PW-1:0] best;
    found = 1'b0;
    best  = '0;
    win   = '0;
    for (int c = 0; c < NCH; c++)
      if (pend[c] && (!found || prio[c] > best)) begin
        found = 1'b1;
        best  = prio[c];
        win   = CH_W'(c);
      end
  end

  assign d_sa  = desc[{ch, 3'd0}];
  assign d_da  = desc[{ch, 3'd1}];
  assign d_nb  = desc[{ch, 3'd2}];
  assign d_off = desc[{ch, 3'd3}];
  assign d_ci  = desc[{ch, 3'd4}][CW-1:0];
  assign d_bi  = desc[{ch, 3'd5}][CW-1:0];
  assign cfg_bad = (d_nb == '0) || (d_nb[1:0] != 2'b00) || (d_sa[1:0] != 2'b00) ||
                   (d_da[1:0] != 2'b00) || (d_ci == '0);

  assign mem_en    = (st == S_RD) || (st == S_WR);
  assign mem_we    = (st == S_WR);
  assign mem_addr  = (st == S_WR) ? da : sa;
  assign mem_wdata = mem_rdata;

  assign irq_done = done_q;
  assign err_flag = err_q;
  assign irq_err  = |(err_q & eei);

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr < A_PRIO) cfg_rdata = desc[cfg_addr[CH_W+2:0]];
    for (int c = 0; c < NCH; c++)
      if (cfg_addr == A_PRIO + RA'(c)) cfg_rdata = 32'(prio[c]);
    if (cfg_addr == A_HWEN) cfg_rdata = 32'(hw_en);
    if (cfg_addr == A_EEI)  cfg_rdata = 32'(eei);
    if (cfg_addr == A_DONE) cfg_rdata = 32'(done_q);
    if (cfg_addr == A_ERR)  cfg_rdata = 32'(err_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH*8; i++) desc[i] <= '0;
      for (int c = 0; c < NCH; c++) prio[c] <= '0;
      hw_en   <= '0;
      eei     <= '0;
      done_q  <= '0;
      err_q   <= '0;
      st      <= S_IDLE;
      ch      <= '0;
      sa      <= '0;
      da      <= '0;
      nb_left <= '0;
      soff    <= '0;
      doff    <= '0;
      citer   <= '0;
      biter   <= '0;
    end else begin
      if (cfg_we) begin
        if (cfg_addr < A_PRIO) desc[cfg_addr[CH_W+2:0]] <= cfg_wdata;
        for (int c = 0; c < NCH; c++)
          if (cfg_addr == A_PRIO + RA'(c)) prio[c] <= cfg_wdata[PW-1:0];
        if (cfg_addr == A_HWEN) hw_en  <= cfg_wdata[NCH-1:0];
        if (cfg_addr == A_EEI)  eei    <= cfg_wdata[NCH-1:0];
        if (cfg_addr == A_DONE) done_q <= done_q & ~cfg_wdata[NCH-1:0];
        if (cfg_addr == A_ERR)  err_q  <= err_q & ~cfg_wdata[NCH-1:0];
      end
      case (st)
        S_IDLE: if (|pend) begin
          ch <= win;
          st <= S_LOAD;
        end
        S_LOAD: begin
          sa      <= d_sa;
          da      <= d_da;
          nb_left <= d_nb;
          soff    <= d_off[15:0];
          doff    <= d_off[31:16];
          citer   <= d_ci;
          biter   <= d_bi;
          if (cfg_bad) begin
            err_q[ch]             <= 1'b1;
            desc[{ch, 3'd6}][0]   <= 1'b0;
            st                    <= S_IDLE;
          end else begin
            st <= S_RD;
          end
        end
        S_RD: st <= S_WR;
        S_WR: begin
          sa      <= sa + {{16{soff[15]}}, soff};
          da      <= da + {{16{doff[15]}}, doff};
          nb_left <= nb_left - 32'd4;
          st      <= (nb_left == 32'd4) ? S_WB : S_RD;
        end
        S_WB: begin
          desc[{ch, 3'd0}] <= sa;
          desc[{ch, 3'd1}] <= da;
          if (citer == CW'(1)) begin
            desc[{ch, 3'd4}]    <= 32'(biter);
            desc[{ch, 3'd6}][0] <= 1'b0;
            hw_en[ch]           <= 1'b0;
            if (desc[{ch, 3'd6}][1]) done_q[ch] <= 1'b1;
          end else begin
            desc[{ch, 3'd4}] <= 32'(citer - CW'(1));
          end
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_desc_engine_chk.sv
module dma_desc_engine_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mem_en,
  input logic           mem_we,
  input logic [1:0]     addr_lo,
  input logic [NCH-1:0] irq_done,
  input logic [NCH-1:0] err_flag
);
  p_aligned_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> addr_lo == 2'b00);

  p_write_follows_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |-> $past(mem_en && !mem_we));

  p_read_then_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we) |=> (mem_en && mem_we));

  p_error_without_traffic_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(err_flag & ~$past(err_flag))) |-> !$past(mem_en));

  p_done_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(irq_done & ~$past(irq_done))) |-> $past(mem_we, 2));
endmodule

bind dma_desc_engine dma_desc_engine_chk #(.NCH(NCH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mem_en   (mem_en),
  .mem_we   (mem_we),
  .addr_lo  (mem_addr[1:0]),
  .irq_done (irq_done),
  .err_flag (err_flag)
);

// File: tb/test_dma_desc_engine.sv
module test_dma_desc_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [3:0]  hw_req = '0;
  logic        mem_en, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic [3:0]  irq_done, err_flag;
  logic        irq_err;

  always #2 clk = ~clk;

  dma_desc_engine i_dma_desc_engine (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .hw_req(hw_req),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq_done(irq_done),
    .err_flag(err_flag), .irq_err(irq_err));

  typedef struct packed { logic [31:0] a; logic [31:0] d; } wr_t;
  wr_t exp_q[$];
  int n_chk = 0, n_bad = 0, n_wr = 0;
  logic [31:0] bmem [256];

  function automatic logic [31:0] pat(input logic [31:0] a);
    return 32'hA500_0000 | a;
  endfunction

  initial for (int i = 0; i < 256; i++) bmem[i] = pat(32'(i * 4));

  always @(posedge clk)
    if (mem_en) begin
      if (mem_we) bmem[mem_addr[9:2]] <= mem_wdata;
      mem_rdata <= bmem[mem_addr[9:2]];
    end

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", r, act, exp);
    end
  endtask

  always @(negedge clk)
    if (rst_n && mem_en && mem_we) begin
      wr_t e;
      n_wr++;
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R5: got write %h <= %h expected no write", mem_addr, mem_wdata);
      end else begin
        e = exp_q.pop_front();
        if ({mem_addr, mem_wdata} !== e) begin
          n_bad++;
          $display("FAIL R5/R6: got %h <= %h expected %h <= %h", mem_addr, mem_wdata, e.a, e.d);
        end
      end
    end

  task automatic push(input logic [31:0] a, input logic [31:0] src);
    exp_q.push_back({a, pat(src)});
  endtask

  task automatic wcfg(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 6'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rcfg(input int a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = 6'(a);
    #1 d = cfg_rdata;
  endtask

  task automatic chkw(input string r, input int ch, input int w, input logic [31:0] exp);
    logic [31:0] v;
    rcfg(ch * 8 + w, v);
    check(r, v, exp);
  endtask

  task automatic wdesc(input int ch, input logic [31:0] sa, input logic [31:0] da,
                       input logic [31:0] nb, input logic [15:0] so, input logic [15:0] dof,
                       input logic [15:0] ci, input logic [15:0] bi, input logic [31:0] csr);
    wcfg(ch*8 + 0, sa);
    wcfg(ch*8 + 1, da);
    wcfg(ch*8 + 2, nb);
    wcfg(ch*8 + 3, {dof, so});
    wcfg(ch*8 + 4, 32'(ci));
    wcfg(ch*8 + 5, 32'(bi));
    wcfg(ch*8 + 6, csr);
  endtask

  task automatic drain();
    wait (exp_q.size() == 0);
    repeat (12) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int w0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 done flags", 32'(irq_done), 0);
    check("R10 error flags", 32'(err_flag), 0);
    check("R10 error irq", 32'(irq_err), 0);
    check("R10 bus idle", 32'(mem_en), 0);
    rcfg(32, v); check("R10 level reg", v, 0);
    rcfg(36, v); check("R10 hw enable", v, 0);
    chkw("R10 descriptor word", 2, 6, 0);

    // R5 R6 R7 R8: two-pass job with completion flag enabled
    push(32'h200, 32'h0); push(32'h204, 32'h4);
    push(32'h208, 32'h8); push(32'h20C, 32'hC);
    wdesc(0, 32'h0, 32'h200, 8, 16'd4, 16'd4, 16'd2, 16'd2, 32'h3);
    drain();
    check("R8 done flag", 32'(irq_done), 32'h1);
    chkw("R6 src advanced", 0, 0, 32'h10);
    chkw("R6 dst advanced", 0, 1, 32'h210);
    chkw("R7 byte count kept", 0, 2, 32'd8);
    chkw("R8 count reloaded", 0, 4, 32'd2);
    chkw("R8 start cleared", 0, 6, 32'h2);

    // R6 negative stride, R8 no flag without enable
    push(32'h280, 32'h48); push(32'h288, 32'h44); push(32'h290, 32'h40);
    wdesc(1, 32'h48, 32'h280, 12, 16'hFFFC, 16'd8, 16'd1, 16'd1, 32'h1);
    drain();
    chkw("R6 src stepped down", 1, 0, 32'h3C);
    chkw("R6 dst stepped", 1, 1, 32'h298);
    chkw("R7 offsets kept", 1, 3, 32'h0008_FFFC);
    chkw("R7 start count kept", 1, 5, 32'd1);
    check("R8 no flag without enable", 32'(irq_done), 32'h1);

    // R3 R4 R11: configuration errors
    w0 = n_wr;
    wdesc(1, 32'h40, 32'h280, 6, 16'd4, 16'd4, 16'd1, 16'd1, 32'h1);
    repeat (10) @(negedge clk);
    check("R3 odd count flagged", 32'(err_flag), 32'h2);
    check("R3 no traffic on error", 32'(n_wr), 32'(w0));
    check("R4 irq masked", 32'(irq_err), 0);
    chkw("R3 start cleared on error", 1, 6, 0);
    chkw("R3 src untouched on error", 1, 0, 32'h40);
    wcfg(37, 32'h2);
    @(negedge clk);
    check("R4 irq enabled", 32'(irq_err), 1);
    wcfg(39, 32'h2);
    @(negedge clk);
    check("R11 error cleared", 32'(err_flag), 0);
    check("R4 irq drops", 32'(irq_err), 0);
    wdesc(2, 32'h140, 32'h342, 4, 16'd4, 16'd4, 16'd1, 16'd1, 32'h1);
    wdesc(3, 32'h140, 32'h340, 4, 16'd4, 16'd4, 16'd0, 16'd1, 32'h1);
    wdesc(0, 32'h140, 32'h340, 0, 16'd4, 16'd4, 16'd1, 16'd1, 32'h1);
    repeat (10) @(negedge clk);
    check("R3 misaligned/zero count/zero iterations", 32'(err_flag), 32'hD);
    wdesc(2, 32'h140, 32'h340, 4, 16'd4, 16'd4, 16'd1, 16'd1, 32'h1);
    repeat (20) @(negedge clk);
    check("R3 flagged channel not served", 32'(n_wr), 32'(w0));
    chkw("R3 start held while masked", 2, 6, 32'h1);
    push(32'h340, 32'h140);
    wcfg(39, 32'hF);
    drain();
    check("R11 all errors cleared", 32'(err_flag), 0);
    wcfg(37, 32'h0);

    // R1 R2: hardware requests, tie then override
    wdesc(0, 32'h20, 32'h220, 4, 16'd4, 16'd4, 16'd1, 16'd1, 32'h2);
    wdesc(1, 32'h60, 32'h260, 4, 16'd4, 16'd4, 16'd1, 16'd1, 32'h2);
    wcfg(32, 2); wcfg(33, 2);
    w0 = n_wr;
    hw_req = 4'b0011;
    repeat (30) @(negedge clk);
    check("R1 request ignored when disabled", 32'(n_wr), 32'(w0));
    push(32'h220, 32'h20); push(32'h260, 32'h60);
    wcfg(36, 32'h3);
    drain();
    rcfg(36, v); check("R8 hw enable cleared", v, 0);
    check("R1 hw jobs done", 32'(irq_done), 32'h3);
    wdesc(0, 32'h24, 32'h224, 4, 16'd4, 16'd4, 16'd1, 16'd1, 32'h2);
    wdesc(1, 32'h64, 32'h264, 4, 16'd4, 16'd4, 16'd1, 16'd1, 32'h2);
    wcfg(32, 1); wcfg(33, 3);
    push(32'h264, 32'h64); push(32'h224, 32'h24);
    wcfg(36, 32'h3);
    drain();
    hw_req = 4'b0000;
    check("R2 override order drained", 32'(exp_q.size()), 0);

    // R9: higher level start lands between passes
    wcfg(34, 1); wcfg(35, 3);
    wdesc(3, 32'h180, 32'h380, 4, 16'd4, 16'd4, 16'd1, 16'd1, 32'h2);
    push(32'h300, 32'h100);
    push(32'h380, 32'h180);
    push(32'h304, 32'h104);
    push(32'h308, 32'h108);
    wdesc(2, 32'h100, 32'h300, 4, 16'd4, 16'd4, 16'd3, 16'd3, 32'h3);
    wait (exp_q.size() == 3);
    wcfg(3*8 + 6, 32'h3);
    drain();
    check("R9 both jobs complete", 32'(irq_done), 32'hF);
    chkw("R9 three passes on channel 2", 2, 0, 32'h10C);

    // R11 completion flag clear
    wcfg(38, 32'h5);
    @(negedge clk);
    check("R11 partial clear", 32'(irq_done), 32'hA);
    wcfg(38, 32'hA);
    @(negedge clk);
    check("R11 full clear", 32'(irq_done), 0);

    finish_run();
  end
endmodule